// File: doc/BRIEF.md
# Watchdog Timer with Protected Control

The block is a watchdog counter that advances once per pulse of a tick enable. The tick comes from a slow free-running oscillator outside the block, near 122 kHz. A four-bit period selector picks a timeout of a power-of-two number of ticks. Software holds the watchdog off by strobing a restart input, which is driven when the core executes its watchdog-restart instruction. If the count runs out, the block either raises an interrupt or sends a one-cycle system reset pulse and sets a sticky reset-cause flag. It can also do both in turn: the interrupt on the first expiry and the reset on the next.

Control sits in one 8-bit register with read and write access. Its layout is: bit 7 interrupt flag, bit 6 interrupt enable, bit 4 change enable, bit 3 watchdog enable. Bit 5 is the MSB of the period selector and bits 2:0 are its low bits. To turn the watchdog off or to change its period, software must first open a short unlock window. Without that step a runaway program cannot silence the watchdog. The reset-cause flag is cleared only by a dedicated clear input or by the block's own reset.

Top module: `wdtGuard`

## Requirements
- R1: After reset the register reads 0x00, and irq, sysReset and rstFlag are all 0.
- R2: The counter advances only in cycles where tick is 1. With tick held at 0 the block never expires.
- R3: A write while the window is closed cannot clear bit 3 and cannot change the selector bits 5 and 2:0. Writing 1 to bit 3 sets the watchdog enable.
- R4: A write with bits 4 and 3 both 1 opens the unlock window. Bit 4 reads 1 while the window is open. A write with bit 4 at 0 during the window loads bit 3 and the selector and then closes the window.
- R5: A loading write is accepted on any of the WIN_CYCLES clock edges after the edge of the opening write. From the next edge on, it is ignored.
- R6: Let P be the selector. After a restart, expiry happens on the 2^(BASE_EXP+P)-th tick.
- R7: sysReset is a pulse exactly one cycle wide. rstFlag rises with it and stays at 1 until rstFlagClr is asserted.
- R8: The counter returns to zero on expiry, so the next expiry comes one full period later.
- R9: A selector value above MAX_SEL gives the same period as MAX_SEL.
- R10: A restart clears the counter. Restarts spaced closer than the period prevent any expiry.
- R11: When bit 6 is set and bit 7 is clear, expiry sets bit 7 instead of resetting. irq equals bit 7 AND bit 6. Writing 1 to bit 7 clears it.
- R12: If both enables are set, the first expiry raises the interrupt. The next expiry, with bit 7 still set, produces the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| restart | input | 1 | Counter restart strobe |
| tick | input | 1 | Slow-oscillator tick enable |
| rstFlagClr | input | 1 | Clears the reset-cause flag |
| irq | output | 1 | Interrupt request |
| sysReset | output | 1 | One-cycle system reset pulse |
| rstFlag | output | 1 | Sticky watchdog reset-cause flag |

## Verification
The bench builds the block with BASE_EXP = 2, MAX_SEL = 9 and WIN_CYCLES = 4. The shortest period is then 4 ticks and the longest is 2048 ticks. This brings the back-to-back expiry, the clamped selector and the interrupt-then-reset sequence within a few thousand cycles. The four-cycle window lets the bench reach both the last accepted edge and the first rejected edge exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic       run;      // count while asserted, hold at zero otherwise
    logic       restart;  // clear the counter this cycle
    logic [3:0] sel;      // period selector
  } wdtStrobes_t;

  localparam int BIT_IFLAG = 7;
  localparam int BIT_IEN   = 6;
  localparam int BIT_SELHI = 5;
  localparam int BIT_CHG   = 4;
  localparam int BIT_WDEN  = 3;
endpackage

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int MAX_SEL  = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdtStrobes_t strobes,
  input  logic        tick,
  output logic        expire
);
  localparam int CNT_W = BASE_EXP + MAX_SEL;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastVal;
  logic [3:0]       effSel;
  int               shamt;

  always_comb begin
    effSel  = (strobes.sel > 4'(MAX_SEL)) ? 4'(MAX_SEL) : strobes.sel;
    shamt   = BASE_EXP + int'(effSel);
    lastVal = {CNT_W{1'b1}} >> (CNT_W - shamt);
    expire  = strobes.run && tick && !strobes.restart && (count == lastVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.restart || !strobes.run) begin
      count <= '0;
    end else if (tick) begin
      count <= expire ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/wdtCtrl.sv
module wdtCtrl
  import wdt_pkg::*;
#(
  parameter int WIN_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        restart,
  input  logic        rstFlagClr,
  input  logic        expire,
  output wdtStrobes_t strobes,
  output logic [7:0]  rdData,
  output logic        irq,
  output logic        sysReset,
  output logic        rstFlag
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);

  logic [WIN_W-1:0] winCnt;
  logic             winOpen, unlockReq, commit, useIrq, fireReset;
  logic             wdEn, irqEn, irqFlag;
  logic [3:0]       sel, newSel;

  always_comb begin
    winOpen   = (winCnt != '0);
    newSel    = {wrData[BIT_SELHI], wrData[2:0]};
    unlockReq = wrEn && wrData[BIT_CHG] && wrData[BIT_WDEN];
    commit    = wrEn && winOpen && !wrData[BIT_CHG];
    useIrq    = irqEn && !irqFlag;
    fireReset = expire && wdEn && !useIrq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt   <= '0;
      wdEn     <= 1'b0;
      sel      <= '0;
      irqEn    <= 1'b0;
      irqFlag  <= 1'b0;
      sysReset <= 1'b0;
      rstFlag  <= 1'b0;
    end else begin
      if (unlockReq)      winCnt <= WIN_W'(WIN_CYCLES);
      else if (commit)    winCnt <= '0;
      else if (winOpen)   winCnt <= winCnt - 1'b1;

      if (commit)                       wdEn <= wrData[BIT_WDEN];
      else if (wrEn && wrData[BIT_WDEN]) wdEn <= 1'b1;

      if (commit) sel <= newSel;
      if (wrEn)   irqEn <= wrData[BIT_IEN];

      if (expire && useIrq)                 irqFlag <= 1'b1;
      else if (wrEn && wrData[BIT_IFLAG])   irqFlag <= 1'b0;

      sysReset <= fireReset;
      if (fireReset)       rstFlag <= 1'b1;
      else if (rstFlagClr) rstFlag <= 1'b0;
    end
  end

  always_comb begin
    strobes.run     = wdEn || irqEn;
    strobes.restart = restart;
    strobes.sel     = sel;
    rdData          = {irqFlag, irqEn, sel[3], winOpen, wdEn, sel[2:0]};
    irq             = irqFlag && irqEn;
  end
endmodule

// File: rtl/wdtGuard.sv
module wdtGuard
  import wdt_pkg::*;
#(
  parameter int BASE_EXP   = 11,
  parameter int MAX_SEL    = 9,
  parameter int WIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       restart,
  input  logic       tick,
  input  logic       rstFlagClr,
  output logic       irq,
  output logic       sysReset,
  output logic       rstFlag
);
  wdtStrobes_t strobes;
  logic        expire;

  wdtCtrl #(.WIN_CYCLES(WIN_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .restart(restart), .rstFlagClr(rstFlagClr), .expire(expire),
    .strobes(strobes), .rdData(rdData), .irq(irq),
    .sysReset(sysReset), .rstFlag(rstFlag)
  );

  wdtDatapath #(.BASE_EXP(BASE_EXP), .MAX_SEL(MAX_SEL)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tick(tick), .expire(expire)
  );
endmodule

// File: rtl/wdtGuardChecker.sv
module wdtGuardChecker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] rdData,
  input logic       restart,
  input logic       rstFlagClr,
  input logic       irq,
  input logic       sysReset,
  input logic       rstFlag
);
  // R7: reset pulse is one cycle wide
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |=> !sysReset);
  // R7: cause flag accompanies the pulse
  a_r7_flag_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |-> rstFlag);
  // R7: cause flag is sticky
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rstFlag && !rstFlagClr) |=> rstFlag);
  // R10: a restart leaves no room for an expiry on that edge
  a_r10_restart_blocks: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !sysReset);
  // R11: interrupt only when its enable is set
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rdData[6]);
  // R3: watchdog enable can only fall while the window is open
  a_r3_no_silent_disable: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[3]) |-> $past(rdData[4]));
endmodule

bind wdtGuard wdtGuardChecker chk_i (
  .clk(clk), .rstN(rstN), .rdData(rdData), .restart(restart),
  .rstFlagClr(rstFlagClr), .irq(irq), .sysReset(sysReset), .rstFlag(rstFlag)
);

// File: tb/wdtGuard_tb.sv
module wdtGuard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       restart = 1'b0;
  logic       tick = 1'b0;
  logic       rstFlagClr = 1'b0;
  logic       irq, sysReset, rstFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdtGuard #(.BASE_EXP(2), .MAX_SEL(9), .WIN_CYCLES(4)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .restart(restart), .tick(tick), .rstFlagClr(rstFlagClr),
    .irq(irq), .sysReset(sysReset), .rstFlag(rstFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearCause();
    rstFlagClr = 1'b1;
    @(negedge clk);
    rstFlagClr = 1'b0;
  endtask

  task automatic configure(input bit wd, input bit ie, input logic [3:0] p);
    tick = 1'b0;
    regWrite({1'b0, ie, 1'b0, 1'b1, 1'b1, 3'b000});
    regWrite({1'b0, ie, p[3], 1'b0, wd, p[2:0]});
    regWrite({1'b1, ie, 6'b000000});
    clearCause();
  endtask

  // Restart, then tick every cycle for n cycles; j = edges after the restart edge
  task automatic runFrom(input int n, output int firstRst, output int rstCnt, output int firstIrq);
    firstRst = 0; rstCnt = 0; firstIrq = 0;
    restart = 1'b1; tick = 1'b0;
    @(negedge clk);
    restart = 1'b0; tick = 1'b1;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (sysReset) begin
        rstCnt++;
        if (firstRst == 0) firstRst = j;
      end
      if (irq && firstIrq == 0) firstIrq = j;
    end
    tick = 1'b0;
  endtask

  task automatic testReset();
    check("R1 rdData", rdData, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 sysReset", sysReset, 0);
    check("R1 rstFlag", rstFlag, 0);
  endtask

  task automatic testProtection();
    regWrite(8'h08);
    check("R3 enable set without unlock", rdData, 8'h08);
    regWrite(8'h27);
    check("R3 locked fields unchanged", rdData, 8'h08);
    regWrite(8'h18);
    check("R4 window open", rdData, 8'h18);
    regWrite(8'h01);
    check("R4 commit loads fields", rdData, 8'h01);
    regWrite(8'h18);
    idle(3);
    regWrite(8'h22);
    check("R5 last accepted edge", rdData, 8'h22);
    regWrite(8'h18);
    idle(4);
    check("R5 window closed", rdData, 8'h2A);
    regWrite(8'h01);
    check("R5 late write ignored", rdData, 8'h2A);
  endtask

  task automatic testPeriods();
    int fr, rc, fi;
    configure(1'b1, 1'b0, 4'd0);
    runFrom(9, fr, rc, fi);
    check("R6 period P=0", fr, 4);
    check("R8 two expiries, R7 one cycle each", rc, 2);
    idle(3);
    check("R7 flag sticky", rstFlag, 1);
    check("R7 no lingering pulse", sysReset, 0);
    clearCause();
    check("R7 flag cleared", rstFlag, 0);
    configure(1'b1, 1'b0, 4'd3);
    runFrom(32, fr, rc, fi);
    check("R6 period P=3", fr, 32);
    configure(1'b1, 1'b0, 4'd12);
    runFrom(2048, fr, rc, fi);
    check("R9 clamped period", fr, 2048);
    check("R9 single expiry", rc, 1);
  endtask

  task automatic testTickAndRestart();
    int fr, rc, fi, total;
    configure(1'b1, 1'b0, 4'd0);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    total = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sysReset) total++;
    end
    check("R2 no expiry without tick", total, 0);
    configure(1'b1, 1'b0, 4'd2);
    total = 0;
    for (int k = 0; k < 5; k++) begin
      runFrom(10, fr, rc, fi);
      total += rc;
    end
    check("R10 restarts keep it quiet", total, 0);
    check("R10 no cause flag", rstFlag, 0);
  endtask

  task automatic testInterrupt();
    int fr, rc, fi;
    configure(1'b0, 1'b1, 4'd0);
    runFrom(6, fr, rc, fi);
    check("R11 irq at expiry", fi, 4);
    check("R11 no reset in irq mode", rc, 0);
    check("R11 flag bit reads 1", rdData[7], 1);
    regWrite(8'hC0);
    check("R11 write-one clears flag", rdData, 8'h40);
    check("R11 irq dropped", irq, 0);
    configure(1'b1, 1'b1, 4'd0);
    runFrom(9, fr, rc, fi);
    check("R12 irq first", fi, 4);
    check("R12 reset on second expiry", fr, 8);
    check("R12 one reset pulse", rc, 1);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testProtection();
    testPeriods();
    testTickAndRestart();
    testInterrupt();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule